// File: doc/BRIEF.md
# One-Wire LED Pixel Serializer

This block turns 24-bit colour pixels into the pulse-width-coded stream that a chain of addressable LEDs reads from a single data wire. Every data bit becomes a high pulse followed by a low remainder. The whole bit slot and the two high widths (one for a zero, one for a one) are programmed in units of a divided clock tick.

Pixels come in over a ready/valid handshake from an upstream FIFO. The block counts the pixels of each frame against a programmed frame length and pulses an event when the last pixel of the frame has left the wire. When the upstream source has nothing left and the shifter is empty, the block can drive a long low latch interval. It then pulses a second event. The level of the idle line is programmable, and a channel-order control swaps the first two colour bytes.

Top module: `led_pixel_serializer`

## Requirements
- R1: After reset, with `enable` high, `sdo` equals `idle_level`, `pix_ready` is 1, and `frame_end` and `latch_done` are 0.
- R2: One tick lasts `div_val`+1 clock cycles, and every timing count below is counted in ticks.
- R3: Each bit slot lasts P×(`div_val`+1) cycles, where P is `period_val` (0 counts as 1). The line is high for the first `t0_high` ticks of a 0 bit or the first `t1_high` ticks of a 1 bit, and low for the rest of the slot.
- R4: A high width that is greater than or equal to P keeps the line high for the whole bit slot.
- R5: Each colour byte is sent most significant bit first. With `grb_order`=0 the bytes go out as `pix_data`[23:16], [15:8], [7:0]. With `grb_order`=1 the order is [15:8], [23:16], [7:0].
- R6: A pixel is taken on a clock edge where `pix_valid` and `pix_ready` are both high. Inside a frame, a pixel offered during the final cycle of the previous pixel's last bit starts in the next cycle, with no gap.
- R7: `frame_end` is a one-cycle pulse in the cycle right after the last bit of the N-th pixel of a frame (N = `frame_pixels`, 0 counts as 1). The line is at idle level in that cycle, `pix_ready` is low in that last bit cycle, and the next pixel starts a new frame.
- R8: With `latch_cmd_en`=1, once pixels have been sent and no pixel is offered while idle, the line is driven low for `latch_period`×(`div_val`+1) cycles whatever `idle_level` is. `latch_done` then pulses for one cycle. No further latch follows until new pixels have been sent.
- R9: With `latch_cmd_en`=0 no latch interval is produced and `latch_done` stays 0. The line stays at idle level after the data.
- R10: Dropping `enable` puts `sdo` at `idle_level` and `pix_ready` at 0 in the same cycle. It also clears the frame position, so that a later frame counts from its first pixel.
- R11: While nothing is being sent, `sdo` equals `idle_level` (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| latch_cmd_en | input | 1 | Enables the automatic latch interval |
| grb_order | input | 1 | 1 swaps the first two colour bytes |
| idle_level | input | 1 | Line level while idle |
| div_val | input | 8 | Tick divider, tick = div_val+1 cycles |
| period_val | input | 8 | Bit slot length in ticks |
| t0_high | input | 8 | High width of a 0 bit in ticks |
| t1_high | input | 8 | High width of a 1 bit in ticks |
| frame_pixels | input | 12 | Pixels per frame |
| latch_period | input | 16 | Latch interval length in ticks |
| pix_valid | input | 1 | Upstream offers a pixel |
| pix_data | input | 24 | Pixel, bytes [23:16],[15:8],[7:0] |
| pix_ready | output | 1 | Serializer accepts a pixel this cycle |
| sdo | output | 1 | Serial LED data line |
| frame_end | output | 1 | One-cycle frame completion pulse |
| latch_done | output | 1 | One-cycle latch completion pulse |

## Verification
The line level is decoded from registered state, so the first bit of an accepted pixel shows on `sdo` in the cycle after the accepting edge. From then on every bit slot fills exactly P×(`div_val`+1) cycles, with no slack. `frame_end` and `latch_done` are registered and become due exactly one cycle after the final bit cycle or the final latch cycle. The driver turns each pixel, frame boundary and latch interval into a per-cycle queue of expected line level and event flags. The monitor starts popping that queue at the first falling edge after the accepting clock edge and compares one entry per cycle, so a one-cycle error in any duration or event shows up as a mismatch.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } ser_state_e;

endpackage

// File: rtl/led_tick_div.sv
module led_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div_val);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // with a divide of two or more, ticks never come on adjacent cycles
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && div_val != '0) |=> !tick);

endmodule

// File: rtl/led_symbol_shaper.sv
module led_symbol_shaper #(
    parameter int TIME_W = 8
) (
    input  logic [TIME_W-1:0] tick_idx,
    input  logic              bit_val,
    input  logic [TIME_W-1:0] zero_high,
    input  logic [TIME_W-1:0] one_high,
    input  logic [TIME_W-1:0] slot_len,
    output logic              line_hi
);
    logic [TIME_W-1:0] high_sel;

    always_comb begin
        high_sel = bit_val ? one_high : zero_high;
        // a width at or beyond the slot saturates to a fully high slot
        if (high_sel >= slot_len) line_hi = 1'b1;
        else                      line_hi = (tick_idx < high_sel);
    end

endmodule

// File: rtl/led_chan_order.sv
module led_chan_order #(
    parameter int CH_W   = 8,
    parameter int NUM_CH = 3
) (
    input  logic [CH_W*NUM_CH-1:0] pix_in,
    input  logic                   swap_first,
    output logic [CH_W*NUM_CH-1:0] pix_out
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        localparam int SWP   = (i == 0) ? 1 : ((i == 1) ? 0 : i);
        localparam int DST   = (NUM_CH - 1 - i) * CH_W;
        localparam int SRC_S = (NUM_CH - 1 - SWP) * CH_W;
        assign pix_out[DST +: CH_W] = swap_first ? pix_in[SRC_S +: CH_W]
                                                 : pix_in[DST +: CH_W];
    end

endmodule

// File: rtl/led_pixel_serializer.sv
module led_pixel_serializer
    import led_ser_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int TIME_W = 8,
    parameter int CNT_W  = 12,
    parameter int RST_W  = 16,
    parameter int CH_W   = 8,
    parameter int NUM_CH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   latch_cmd_en,
    input  logic                   grb_order,
    input  logic                   idle_level,
    input  logic [DIV_W-1:0]       div_val,
    input  logic [TIME_W-1:0]      period_val,
    input  logic [TIME_W-1:0]      t0_high,
    input  logic [TIME_W-1:0]      t1_high,
    input  logic [CNT_W-1:0]       frame_pixels,
    input  logic [RST_W-1:0]       latch_period,
    input  logic                   pix_valid,
    input  logic [CH_W*NUM_CH-1:0] pix_data,
    output logic                   pix_ready,
    output logic                   sdo,
    output logic                   frame_end,
    output logic                   latch_done
);
    localparam int PIX_W = CH_W * NUM_CH;
    localparam int IDX_W = $clog2(PIX_W);

    typedef struct packed {
        ser_state_e       st;
        logic [TIME_W-1:0] tcnt;
        logic [IDX_W-1:0]  bidx;
        logic [PIX_W-1:0]  sh;
        logic [CNT_W-1:0]  left;
        logic [RST_W-1:0]  rcnt;
        logic              dirty;
        logic              fend;
        logic              rdone;
    } ser_regs_t;

    ser_regs_t r_d, r_q;

    logic              tick;
    logic              run;
    logic              line_hi;
    logic [PIX_W-1:0]  pix_ordered;
    logic [TIME_W-1:0] slot_eff;
    logic [RST_W-1:0]  latch_eff;
    logic [CNT_W-1:0]  frame_eff;
    logic              bit_end;
    logic              last_bit;
    logic              pix_done;
    logic              accept;

    assign slot_eff  = (period_val   == '0) ? TIME_W'(1) : period_val;
    assign latch_eff = (latch_period == '0) ? RST_W'(1)  : latch_period;
    assign frame_eff = (frame_pixels == '0) ? CNT_W'(1)  : frame_pixels;
    assign run       = enable && (r_q.st != ST_IDLE);

    led_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_val (div_val),
        .tick    (tick)
    );

    led_symbol_shaper #(.TIME_W(TIME_W)) u_shape (
        .tick_idx  (r_q.tcnt),
        .bit_val   (r_q.sh[PIX_W-1]),
        .zero_high (t0_high),
        .one_high  (t1_high),
        .slot_len  (slot_eff),
        .line_hi   (line_hi)
    );

    led_chan_order #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_order (
        .pix_in     (pix_data),
        .swap_first (grb_order),
        .pix_out    (pix_ordered)
    );

    assign bit_end  = (r_q.st == ST_SHIFT) && tick && (r_q.tcnt == slot_eff - TIME_W'(1));
    assign last_bit = (r_q.bidx == IDX_W'(PIX_W - 1));
    assign pix_done = bit_end && last_bit;
    assign pix_ready = enable && ((r_q.st == ST_IDLE) ||
                                  (pix_done && r_q.left != CNT_W'(1)));
    assign accept   = pix_ready && pix_valid;

    always_comb begin
        r_d       = r_q;
        r_d.fend  = 1'b0;
        r_d.rdone = 1'b0;
        if (!enable) begin
            r_d = '0;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (accept) begin
                        r_d.st   = ST_SHIFT;
                        r_d.sh   = pix_ordered;
                        r_d.bidx = '0;
                        r_d.tcnt = '0;
                        r_d.left = (r_q.left == '0) ? frame_eff : r_q.left;
                    end else if (latch_cmd_en && r_q.dirty) begin
                        r_d.st   = ST_LATCH;
                        r_d.rcnt = '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (r_q.tcnt == slot_eff - TIME_W'(1)) begin
                            r_d.tcnt = '0;
                            if (last_bit) begin
                                r_d.dirty = 1'b1;
                                r_d.left  = r_q.left - 1'b1;
                                if (r_q.left == CNT_W'(1)) r_d.fend = 1'b1;
                                if (accept) begin
                                    r_d.sh   = pix_ordered;
                                    r_d.bidx = '0;
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end else begin
                                r_d.bidx = r_q.bidx + 1'b1;
                                r_d.sh   = r_q.sh << 1;
                            end
                        end else begin
                            r_d.tcnt = r_q.tcnt + 1'b1;
                        end
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        if (r_q.rcnt == latch_eff - RST_W'(1)) begin
                            r_d.st    = ST_IDLE;
                            r_d.rdone = 1'b1;
                            r_d.dirty = 1'b0;
                        end else begin
                            r_d.rcnt = r_q.rcnt + 1'b1;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (!enable)                 sdo = idle_level;
        else if (r_q.st == ST_SHIFT) sdo = line_hi;
        else if (r_q.st == ST_LATCH) sdo = 1'b0;
        else                         sdo = idle_level;
    end

    assign frame_end  = r_q.fend;
    assign latch_done = r_q.rdone;

    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (r_q.st == ST_IDLE && !frame_end && !latch_done));

    p_fend_after_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ($past(r_q.st) == ST_SHIFT && !latch_done));

    p_done_after_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_done |-> ($past(r_q.st) == ST_LATCH));

    p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && r_q.st == ST_SHIFT && !tick) |=> $stable(r_q.sh));

    p_bit_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bidx <= IDX_W'(PIX_W - 1));

endmodule

// File: tb/tb_led_pixel_serializer.sv
`timescale 1ns/1ps
module tb_led_pixel_serializer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, latch_cmd_en, grb_order, idle_level;
    logic [7:0]  div_val, period_val, t0_high, t1_high;
    logic [11:0] frame_pixels;
    logic [15:0] latch_period;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        pix_ready, sdo, frame_end, latch_done;

    always #2.5 clk = ~clk;

    led_pixel_serializer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .latch_cmd_en(latch_cmd_en),
        .grb_order(grb_order), .idle_level(idle_level), .div_val(div_val),
        .period_val(period_val), .t0_high(t0_high), .t1_high(t1_high),
        .frame_pixels(frame_pixels), .latch_period(latch_period),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .sdo(sdo), .frame_end(frame_end), .latch_done(latch_done)
    );

    typedef struct { bit lvl; bit fe; bit re; int tag; } samp_t;
    samp_t exp_q[$];

    int  n_cmp = 0, n_bad = 0;
    bit  go = 0;
    int  fe_seen = 0, rd_seen = 0;
    int  pos = 0;
    bit  finished = 0;

    function automatic string rtag(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(bit ok, int tag, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", rtag(tag), what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: one expected entry per cycle once a stream has been accepted
    always @(negedge clk) begin
        if (frame_end)  fe_seen++;
        if (latch_done) rd_seen++;
        if (go && exp_q.size() > 0) begin
            samp_t e;
            e = exp_q.pop_front();
            chk(sdo == e.lvl, e.tag, "sdo level", int'(sdo), int'(e.lvl));
            chk(frame_end == e.fe, 7, "frame_end", int'(frame_end), int'(e.fe));
            chk(latch_done == e.re, 8, "latch_done", int'(latch_done), int'(e.re));
            if (exp_q.size() == 0) go = 0;
        end
    end

    function automatic logic [23:0] order_px(logic [23:0] p, bit g);
        return g ? {p[15:8], p[23:16], p[7:0]} : p;
    endfunction

    task automatic push_const(bit lvl, int n, bit fe, bit re, int tag);
        for (int k = 0; k < n; k++) begin
            samp_t s;
            s.lvl = lvl; s.fe = fe; s.re = re; s.tag = tag;
            exp_q.push_back(s);
        end
    endtask

    task automatic push_pixel(logic [23:0] p, int tag);
        logic [23:0] o;
        int tk, per, h;
        o   = order_px(p, grb_order);
        tk  = int'(div_val) + 1;
        per = (period_val == 0) ? 1 : int'(period_val);
        for (int b = 23; b >= 0; b--) begin
            h = o[b] ? int'(t1_high) : int'(t0_high);
            if (h > per) h = per;
            for (int k = 0; k < per * tk; k++) begin
                samp_t s;
                s.lvl = (k < h * tk); s.fe = 0; s.re = 0; s.tag = tag;
                exp_q.push_back(s);
            end
        end
    endtask

    task automatic send_stream(input logic [23:0] px [4], input int n, input int tag,
                               input bit exp_latch);
        for (int i = 0; i < n; i++) begin
            push_pixel(px[i], tag);
            pos++;
            if (pos == int'(frame_pixels)) begin
                pos = 0;
                push_const(idle_level, 1, 1, 0, 7);
            end
        end
        if (exp_latch) begin
            push_const(idle_level, 1, 0, 0, 8);
            push_const(1'b0, int'(latch_period) * (int'(div_val) + 1), 0, 0, 8);
            push_const(idle_level, 1, 0, 1, 8);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_data  = px[i];
            while (!pix_ready) @(negedge clk);
            @(posedge clk);
            if (i == 0) go = 1;
        end
        @(negedge clk);
        pix_valid = 1'b0;
        wait (go == 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic reconfig();
        @(negedge clk);
        enable = 1'b0;
        pos = 0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        logic [23:0] px [4];
        int rd0;
        rst_n = 1'b0; enable = 1'b1; latch_cmd_en = 1'b0; grb_order = 1'b0;
        idle_level = 1'b0; div_val = 8'd0; period_val = 8'd4;
        t0_high = 8'd1; t1_high = 8'd3; frame_pixels = 12'd100;
        latch_period = 16'd5; pix_valid = 1'b0; pix_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sdo == 1'b0, 1, "sdo after reset", int'(sdo), 0);
        chk(pix_ready == 1'b1, 1, "pix_ready after reset", int'(pix_ready), 1);
        chk(frame_end == 1'b0, 1, "frame_end after reset", int'(frame_end), 0);
        chk(latch_done == 1'b0, 1, "latch_done after reset", int'(latch_done), 0);

        // R3 and R5: RGB order, MSB first
        px[0] = 24'hA53CF0;
        send_stream(px, 1, 3, 0);

        // R2: divided tick
        div_val = 8'd2; period_val = 8'd5; t0_high = 8'd2; t1_high = 8'd4;
        reconfig();
        px[0] = 24'h0F817E;
        send_stream(px, 1, 2, 0);

        // R5: swapped first two bytes
        div_val = 8'd0; period_val = 8'd4; t0_high = 8'd1; t1_high = 8'd3;
        grb_order = 1'b1;
        reconfig();
        px[0] = 24'h123456;
        send_stream(px, 1, 5, 0);
        grb_order = 1'b0;

        // R4: high width above and equal to the slot
        t1_high = 8'd6;
        reconfig();
        px[0] = 24'hC30081;
        send_stream(px, 1, 4, 0);
        t1_high = 8'd4; t0_high = 8'd2;
        reconfig();
        px[0] = 24'h9A5501;
        send_stream(px, 1, 4, 0);

        // R6 and R7: back-to-back with a frame of two pixels
        t0_high = 8'd1; t1_high = 8'd3; frame_pixels = 12'd2;
        reconfig();
        fe_seen = 0;
        px[0] = 24'hF0F0F0; px[1] = 24'h0A0B0C; px[2] = 24'h813C7E;
        send_stream(px, 3, 6, 0);
        chk(fe_seen == 1, 7, "frame_end pulses", fe_seen, 1);

        // R10: disable mid-pixel
        reconfig();
        @(negedge clk);
        pix_valid = 1'b1; pix_data = 24'hFFFFFF;
        while (!pix_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
        chk(sdo == 1'b1, 10, "sdo before disable", int'(sdo), 1);
        enable = 1'b0;
        #1;
        chk(sdo == 1'b0, 10, "sdo on disable", int'(sdo), 0);
        chk(pix_ready == 1'b0, 10, "pix_ready on disable", int'(pix_ready), 0);
        @(negedge clk);
        chk(sdo == 1'b0, 10, "sdo while disabled", int'(sdo), 0);
        enable = 1'b1;
        #1;
        chk(pix_ready == 1'b1, 10, "pix_ready re-enabled", int'(pix_ready), 1);
        pos = 0;
        fe_seen = 0;
        px[0] = 24'h112233; px[1] = 24'h445566;
        send_stream(px, 2, 10, 0);
        chk(fe_seen == 1, 10, "frame count restarted", fe_seen, 1);

        // R8 and R11: latch interval with idle level high
        frame_pixels = 12'd100; div_val = 8'd1; latch_period = 16'd5;
        idle_level = 1'b1; latch_cmd_en = 1'b1;
        reconfig();
        chk(sdo == 1'b1, 11, "idle level high", int'(sdo), 1);
        px[0] = 24'h5AA5C3;
        send_stream(px, 1, 8, 1);
        rd0 = rd_seen;
        repeat (200) @(negedge clk);
        chk(rd_seen == rd0, 8, "no repeated latch", rd_seen, rd0);
        chk(sdo == 1'b1, 11, "idle after latch", int'(sdo), 1);

        // R9: latch function off
        latch_cmd_en = 1'b0;
        reconfig();
        rd0 = rd_seen;
        px[0] = 24'h00FF00;
        send_stream(px, 1, 9, 0);
        repeat (100) @(negedge clk);
        chk(rd_seen == rd0, 9, "no latch when off", rd_seen, rd0);
        chk(sdo == 1'b1, 9, "line idle without latch", int'(sdo), 1);

        summary();
    end

endmodule